// File: doc/BRIEF.md
# PCM Serial Transmit Port

This block takes one already-companded 8-bit voice sample per frame and sends it serially onto a time-division-multiplexed bus, most significant bit first. All logic runs on the master clock. In fixed-rate mode that clock is also the bit clock. One bit leaves on every master-clock cycle, starting with the edge that detects the rising frame-sync edge. In variable-rate mode a separate, slower data clock sets the pace. It is sampled on the master clock, and each of its rising edges moves the output to the next bit. In this mode the frame-sync line doubles as a time-slot enable, and the serial output is driven only while that line is high.

In fixed-rate mode, the length of the frame-sync pulse tells the two frame kinds apart. A pulse one master-clock cycle long marks a normal frame. A pulse that is still high on the following edge marks a signaling frame. On a signaling frame the last bit sent, which is the LSB, is replaced by the level of a signaling input. While a fixed-rate word is on the bus, the block raises a slot strobe that can enable an external tri-state driver. An indicator reports standby once frame sync has stayed low for a set number of master-clock cycles, which is a parameter.

Top module: `pcm_tx_port`

## Requirements
- R1: While reset is held and just after its release, txOe, txData, slotStrobe and standby are all 0.
- R2: In fixed-rate mode (modeVar=0), the master-clock edge that first samples frameSync high loads sampleIn. From the cycle after that edge, txOe is 1 and txData carries sampleIn bit 7, then bits 6 down to 0, one per master-clock cycle.
- R3: A frameSync pulse lasting a single cycle marks a normal frame, and the eighth bit sent is sampleIn bit 0, whatever sigIn is.
- R4: A frameSync pulse that is still high on the edge after the loading edge marks a signaling frame. The eighth bit sent is the level of sigIn sampled on the edge that presents that bit.
- R5: In variable-rate mode (modeVar=1), bit 7 is presented after the loading edge. Each later master-clock edge that sees dataClk high, where the previous edge saw it low, presents the next bit. The step after bit 0 ends the slot.
- R6: In variable-rate mode, txOe is 1 only while a slot is active and frameSync is high. Whenever txOe is 0, txData is 0.
- R7: In fixed-rate mode, slotStrobe equals txOe and stays high for exactly 8 cycles per word. In variable-rate mode, slotStrobe stays 0.
- R8: standby rises after frameSync has been sampled low on STANDBY_CYCLES consecutive edges. The first edge that samples frameSync high clears it.
- R9: A new frameSync rising edge during an active slot restarts the word with the newly loaded sample.
- R10: In variable-rate mode the LSB is never replaced, even when frameSync stays high through the slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeVar | input | 1 | 0 = fixed-rate, 1 = variable-rate |
| frameSync | input | 1 | Frame sync / time-slot enable |
| dataClk | input | 1 | Variable-rate data clock, sampled on clk |
| sampleIn | input | WORD_BITS | Encoded sample, loaded on frame-sync rise |
| sigIn | input | 1 | Signaling bit for signaling frames |
| txData | output | 1 | Serial data, 0 when not enabled |
| txOe | output | 1 | Output enable for the serial line |
| slotStrobe | output | 1 | Fixed-rate time-slot strobe |
| standby | output | 1 | Idle-standby indicator |

## Verification
Every serial bit, slotStrobe and standby is registered. Each therefore changes one master-clock edge after the edge that samples its cause: a frame-sync rise, a sampled data-clock rise, or the last low sample of frame sync. In variable-rate mode, txOe also follows frameSync within the same cycle. A behavioural model in the bench is advanced on each rising edge with the inputs held stable across that edge. The outputs are compared with it at the following falling edge, and new stimulus is applied only after that comparison. As a result, each expected value is checked exactly one register stage after its cause.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  // Control-to-datapath strobes for one master-clock cycle.
  typedef struct packed {
    logic load;     // capture a new sample, present its MSB
    logic shift;    // present the next bit
    logic lastBit;  // the bit being presented is the LSB
    logic sigSet;   // this frame is a signaling frame
  } txStrobes_t;
endpackage

// File: rtl/pcm_tx_ctrl.sv
module pcm_tx_ctrl
  import pcm_tx_pkg::*;
#(
  parameter int WORD_BITS      = 8,
  parameter int STANDBY_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       modeVar,
  input  logic       frameSync,
  input  logic       dataClk,
  output txStrobes_t strobes,
  output logic       active,
  output logic       standby
);
  localparam int CNT_W = $clog2(WORD_BITS);
  localparam int SB_W  = $clog2(STANDBY_CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);
  localparam logic [SB_W-1:0]  SB_LIMIT = SB_W'(STANDBY_CYCLES);

  logic             fsPrev, dcPrev;
  logic [CNT_W-1:0] bitCnt;
  logic [SB_W-1:0]  idleCnt;
  logic             fsRise, step, slotStep;

  assign fsRise   = frameSync & ~fsPrev;
  assign step     = modeVar ? (dataClk & ~dcPrev) : 1'b1;
  assign slotStep = active & step & ~fsRise;

  always_comb begin
    strobes.load    = fsRise;
    strobes.shift   = slotStep & (bitCnt != LAST_IDX);
    strobes.lastBit = slotStep & (bitCnt == LAST_IDX - 1'b1);
    strobes.sigSet  = slotStep & (bitCnt == '0) & ~modeVar & frameSync;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsPrev <= 1'b0;
      dcPrev <= 1'b0;
    end else begin
      fsPrev <= frameSync;
      dcPrev <= dataClk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      bitCnt <= '0;
    end else if (fsRise) begin
      active <= 1'b1;
      bitCnt <= '0;
    end else if (slotStep) begin
      if (bitCnt == LAST_IDX) active <= 1'b0;
      else                    bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
      standby <= 1'b0;
    end else if (frameSync) begin
      idleCnt <= '0;
      standby <= 1'b0;
    end else if (idleCnt != SB_LIMIT) begin
      idleCnt <= idleCnt + 1'b1;
      if (idleCnt == SB_LIMIT - 1'b1) standby <= 1'b1;
    end
  end
endmodule

// File: rtl/pcm_tx_datapath.sv
module pcm_tx_datapath
  import pcm_tx_pkg::*;
#(
  parameter int WORD_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  txStrobes_t           strobes,
  input  logic [WORD_BITS-1:0] sampleIn,
  input  logic                 sigIn,
  output logic                 bitOut
);
  logic [WORD_BITS-1:0] shiftReg;
  logic                 sigFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitOut   <= 1'b0;
      sigFrame <= 1'b0;
    end else if (strobes.load) begin
      shiftReg <= sampleIn;
      bitOut   <= sampleIn[WORD_BITS-1];
      sigFrame <= 1'b0;
    end else begin
      if (strobes.sigSet) sigFrame <= 1'b1;
      if (strobes.shift) begin
        shiftReg <= shiftReg << 1;
        bitOut   <= (strobes.lastBit && sigFrame) ? sigIn : shiftReg[WORD_BITS-2];
      end
    end
  end
endmodule

// File: rtl/pcm_tx_port.sv
module pcm_tx_port
  import pcm_tx_pkg::*;
#(
  parameter int WORD_BITS      = 8,
  parameter int STANDBY_CYCLES = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 modeVar,
  input  logic                 frameSync,
  input  logic                 dataClk,
  input  logic [WORD_BITS-1:0] sampleIn,
  input  logic                 sigIn,
  output logic                 txData,
  output logic                 txOe,
  output logic                 slotStrobe,
  output logic                 standby
);
  txStrobes_t strobes;
  logic       active;
  logic       bitOut;

  pcm_tx_ctrl #(.WORD_BITS(WORD_BITS), .STANDBY_CYCLES(STANDBY_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .modeVar(modeVar), .frameSync(frameSync),
    .dataClk(dataClk), .strobes(strobes), .active(active), .standby(standby)
  );

  pcm_tx_datapath #(.WORD_BITS(WORD_BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sampleIn(sampleIn),
    .sigIn(sigIn), .bitOut(bitOut)
  );

  assign txOe       = active & (~modeVar | frameSync);
  assign slotStrobe = active & ~modeVar;
  assign txData     = txOe & bitOut;
endmodule

// File: rtl/pcm_tx_port_chk.sv
module pcm_tx_port_chk #(
  parameter int WORD_BITS = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 modeVar,
  input logic                 frameSync,
  input logic [WORD_BITS-1:0] sampleIn,
  input logic                 txData,
  input logic                 txOe,
  input logic                 slotStrobe,
  input logic                 standby
);
  logic       fsQ;
  logic [7:0] strobeRun;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fsQ       <= 1'b0;
      strobeRun <= '0;
    end else begin
      fsQ <= frameSync;
      if (frameSync && !fsQ)                strobeRun <= '0;
      else if (slotStrobe && strobeRun != 8'hFF) strobeRun <= strobeRun + 1'b1;
    end
  end

  p_msb_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    (frameSync && !fsQ && !modeVar) |=> (slotStrobe && txData == $past(sampleIn[WORD_BITS-1])));

  p_oe_gated_r6: assert property (@(posedge clk) disable iff (!rstN)
    (modeVar && !frameSync) |-> !txOe);

  p_strobe_len_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobeRun <= 8'(WORD_BITS));

  p_standby_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    frameSync |=> !standby);

  p_data_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!modeVar && !slotStrobe) |-> (!txOe && !txData));
endmodule

bind pcm_tx_port pcm_tx_port_chk #(.WORD_BITS(WORD_BITS)) u_chk (
  .clk(clk), .rstN(rstN), .modeVar(modeVar), .frameSync(frameSync),
  .sampleIn(sampleIn), .txData(txData), .txOe(txOe),
  .slotStrobe(slotStrobe), .standby(standby)
);

// File: tb/pcm_tx_port_tb.sv
module pcm_tx_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WB         = 8;
  localparam int SB_LIM     = 20;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeVar = 1'b0, frameSync = 1'b0, dataClk = 1'b0, sigIn = 1'b0;
  logic [WB-1:0] sampleIn = '0;
  logic txData, txOe, slotStrobe, standby;

  int checks = 0, errors = 0;
  bit done = 0;
  string dataTag = "R2";

  // behavioural reference state
  bit mFsPrev, mDcPrev, mActive, mSig, mBit, mSb;
  int mIdx, mIdle;
  logic [WB-1:0] mWord;

  pcm_tx_port #(.WORD_BITS(WB), .STANDBY_CYCLES(SB_LIM)) u_dut (
    .clk(clk), .rstN(rstN), .modeVar(modeVar), .frameSync(frameSync),
    .dataClk(dataClk), .sampleIn(sampleIn), .sigIn(sigIn), .txData(txData),
    .txOe(txOe), .slotStrobe(slotStrobe), .standby(standby)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, string what, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic modelStep();
    bit rise, stepOk;
    if (!rstN) begin
      mFsPrev = 0; mDcPrev = 0; mActive = 0; mSig = 0; mBit = 0;
      mSb = 0; mIdx = 0; mIdle = 0; mWord = '0;
      return;
    end
    rise   = frameSync && !mFsPrev;
    stepOk = modeVar ? (dataClk && !mDcPrev) : 1'b1;
    if (rise) begin
      mWord = sampleIn; mIdx = WB - 1; mActive = 1; mSig = 0; mBit = sampleIn[WB-1];
    end else if (mActive && stepOk) begin
      if (mIdx == WB - 1 && !modeVar) mSig = frameSync;
      if (mIdx == 0) mActive = 0;
      else begin
        mIdx--;
        mBit = (mIdx == 0 && mSig) ? sigIn : mWord[mIdx];
      end
    end
    if (frameSync) begin mIdle = 0; mSb = 0; end
    else if (mIdle < SB_LIM) begin
      mIdle++;
      if (mIdle == SB_LIM) mSb = 1;
    end
    mFsPrev = frameSync; mDcPrev = dataClk;
  endtask

  task automatic tick();
    bit eOe;
    @(posedge clk);
    modelStep();
    @(negedge clk);
    eOe = mActive && (modeVar ? frameSync : 1'b1);
    chk(modeVar ? "R6" : "R2", "txOe", txOe, eOe);
    chk(dataTag, "txData", txData, eOe ? mBit : 1'b0);
    chk("R7", "slotStrobe", slotStrobe, mActive && !modeVar);
    chk("R8", "standby", standby, mSb);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic fixedFrame(logic [WB-1:0] s, int pulse, logic sg, string tag);
    dataTag = tag; sampleIn = s; sigIn = sg; frameSync = 1'b1;
    for (int i = 0; i < pulse; i++) tick();
    frameSync = 1'b0;
    idle(10);
  endtask

  // variable-rate frame: dataClk toggles every 2 master cycles
  task automatic varFrame(logic [WB-1:0] s, int slotLen, logic sg, string tag);
    dataTag = tag; sampleIn = s; sigIn = sg; frameSync = 1'b1;
    for (int i = 0; i < 44; i++) begin
      if (i == slotLen) frameSync = 1'b0;
      if (i % 2 == 1) dataClk = ~dataClk;
      tick();
    end
    frameSync = 1'b0;
    idle(4);
  endtask

  initial begin
    modelStep();
    idle(3);
    chk("R1", "txOe in reset", txOe, 1'b0);
    chk("R1", "standby in reset", standby, 1'b0);
    rstN = 1'b1;
    tick();
    chk("R1", "slotStrobe after reset", slotStrobe, 1'b0);
    chk("R1", "txData after reset", txData, 1'b0);
    dataTag = "R8";
    idle(SB_LIM + 3);                        // standby rises (R8)
    fixedFrame(8'h96, 1, 1'b0, "R2");        // clears standby, MSB first
    fixedFrame(8'h3C, 1, 1'b1, "R3");        // normal frame, sigIn ignored
    fixedFrame(8'h81, 2, 1'b0, "R4");        // signaling, LSB forced 0
    fixedFrame(8'h5A, 2, 1'b1, "R4");        // signaling, LSB forced 1
    // restart during a slot (R9)
    dataTag = "R9"; sampleIn = 8'hF0; frameSync = 1'b1; tick();
    frameSync = 1'b0; idle(3);
    sampleIn = 8'h0F; frameSync = 1'b1; tick();
    frameSync = 1'b0; idle(12);
    modeVar = 1'b1; idle(2);
    varFrame(8'hA7, 40, 1'b0, "R5");         // full slot
    varFrame(8'hC3, 9, 1'b0, "R6");          // enable drops mid-slot
    varFrame(8'h2E, 40, 1'b1, "R10");        // no LSB substitution
    modeVar = 1'b0;
    dataTag = "R8";
    idle(SB_LIM + 4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule